// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple word-request port and a 1M x 16 extended-data-out DRAM. A request carries a 20-bit word address, 16 bits of write data, a two-bit byte-lane mask and a read/write flag. The controller turns each request into registered strobe waveforms: one row strobe, two column strobes (one per byte lane), write enable, output enable, and a shared 10-bit address bus that carries the row and then the column.

The controller keeps the last row open. A request to the same row runs as a page cycle: the row strobe stays low and only the column strobes pulse. A request to a different row first closes the row and waits a precharge time. A free-running timer raises refresh requests. These are served as CAS-before-RAS cycles between host accesses, so the controller never has to supply a refresh address. All timing intervals are parameters counted in system clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset, `mem_ras_n`, both column strobes, `mem_we_n` and `mem_oe_n` are high, `host_ready` is high and `rsp_valid` is low.
- R2: The row strobe falls with `mem_addr` = `host_addr[19:10]`. The column strobes fall with `mem_addr` = `host_addr[9:0]`.
- R3: `host_be[0]` selects `mem_lcas_n`, which carries bits 7:0. `host_be[1]` selects `mem_ucas_n`, which carries bits 15:8. A byte lane that is not selected is neither written nor returned: its bits in `rsp_rdata` read as zero.
- R4: Writes are early writes. `mem_we_n` is already low in the cycle before a column strobe falls, and `mem_oe_n` stays high.
- R5: During a read, `mem_we_n` stays high and `mem_oe_n` is low only while a column strobe is low. Read data is returned on `rsp_rdata` together with a `rsp_valid` pulse that lasts exactly one cycle.
- R6: An access to the row that is currently open produces no new falling edge of the row strobe.
- R7: An access to a different row raises the row strobe. Before every falling edge of the row strobe, it has been high for at least `T_RP` cycles.
- R8: A refresh drops both column strobes while the row strobe is high, then drops the row strobe. During the refresh `mem_addr` does not change and `mem_we_n` and `mem_oe_n` stay high.
- R9: When the bus is idle, refreshes are spaced by P*`CLK_MHZ`/1024 cycles. P is 16000 µs, or 128000 µs when `EXT_REFRESH`=1.
- R10: A pending refresh is served before a waiting host request, once the current column cycle has finished. The refresh leaves the row closed, so the next access opens a row.
- R11: `host_ready` is high only while the controller is idle with no refresh pending, and never while a column strobe is low. One request is accepted per valid/ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request valid |
| host_ready | output | 1 | Request accepted when high together with valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address, row in upper half, column in lower half |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte-lane select, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ras_n | output | 1 | Row strobe |
| mem_lcas_n | output | 1 | Lower-byte column strobe |
| mem_ucas_n | output | 1 | Upper-byte column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_oe_n | output | 1 | Output enable |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_dq_out | output | 16 | Data driven to the DRAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench builds the controller with `CLK_MHZ`=3 and `EXT_REFRESH`=1, which gives a refresh every 375 cycles. At that spacing several refreshes fall inside a long stream of back-to-back reads, so R9 and R10 can be checked within a short run. The column, precharge and CAS-before-RAS setup times are all set to two cycles or fewer, so the table of page hits, misses and byte-masked accesses finishes before the first refresh is due.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_MISS,
        ST_ROW_SET,
        ST_ROW_WAIT,
        ST_COL_SET,
        ST_COL_LOW,
        ST_COL_REC,
        ST_PRE_REF,
        ST_REF_CAS,
        ST_REF_RAS,
        ST_REF_REC
    } ctrl_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         pend_d, pend_q;

    always_comb begin
        cnt_d  = cnt_q + W'(1);
        pend_d = pend_q;
        if (ack) begin
            pend_d = 1'b0;
        end
        if (cnt_q == W'(INTERVAL - 1)) begin
            cnt_d  = '0;
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    input  logic                   row_open,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   hit
);
    always_comb begin
        row = addr[ROW_W+COL_W-1:COL_W];
        col = addr[COL_W-1:0];
        hit = row_open && (row == open_row);
    end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
    parameter int ROW_W       = 10,
    parameter int COL_W       = 10,
    parameter int DATA_W      = 16,
    parameter int CLK_MHZ     = 100,
    parameter int EXT_REFRESH = 0,
    parameter int T_RCD       = 2,
    parameter int T_CAS       = 2,
    parameter int T_CP        = 1,
    parameter int T_RP        = 3,
    parameter int T_CSR       = 1,
    parameter int T_RAS_REF   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_valid,
    output logic                   host_ready,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    input  logic [1:0]             host_be,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   mem_ras_n,
    output logic                   mem_lcas_n,
    output logic                   mem_ucas_n,
    output logic                   mem_we_n,
    output logic                   mem_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    import edo_pkg::*;

    localparam int PIN_W      = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int LANE_W     = DATA_W / 2;
    localparam int PERIOD_US  = (EXT_REFRESH != 0) ? 128000 : 16000;
    localparam int REF_ROWS   = 1 << ROW_W;
    localparam int REF_CYCLES = PERIOD_US * CLK_MHZ / REF_ROWS;
    localparam int MAX_T      = max_of(max_of(max_of(T_RCD, T_CAS), max_of(T_CP, T_RP)),
                                       max_of(T_CSR, T_RAS_REF));
    localparam int CNT_W      = $clog2(MAX_T + 1);

    typedef struct packed {
        ctrl_state_e        st;
        logic [CNT_W-1:0]   cnt;
        logic               ras_n;
        logic               lcas_n;
        logic               ucas_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
        logic [PIN_W-1:0]   pin;
        logic [DATA_W-1:0]  wdata;
        logic               is_we;
        logic [1:0]         be;
        logic [COL_W-1:0]   col;
        logic               row_open;
        logic [ROW_W-1:0]   row;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rdata;
    } ctrl_t;

    localparam ctrl_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, ras_n: 1'b1, lcas_n: 1'b1, ucas_n: 1'b1,
        we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, pin: '0, wdata: '0,
        is_we: 1'b0, be: '0, col: '0, row_open: 1'b0, row: '0,
        rsp_valid: 1'b0, rdata: '0
    };

    ctrl_t s_d, s_q;

    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             req_hit;
    logic             accept;

    edo_refresh_timer #(.INTERVAL(REF_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .pend  (ref_pend)
    );

    edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr     (host_addr),
        .open_row (s_q.row),
        .row_open (s_q.row_open),
        .row      (req_row),
        .col      (req_col),
        .hit      (req_hit)
    );

    assign host_ready = (s_q.st == ST_IDLE) && !ref_pend;
    assign accept     = host_valid && host_ready;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        ref_ack       = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_ack = 1'b1;
                    if (s_q.row_open) begin
                        s_d.ras_n    = 1'b1;
                        s_d.row_open = 1'b0;
                        s_d.cnt      = CNT_W'(T_RP - 1);
                        s_d.st       = ST_PRE_REF;
                    end else begin
                        s_d.lcas_n = 1'b0;
                        s_d.ucas_n = 1'b0;
                        s_d.cnt    = CNT_W'(T_CSR - 1);
                        s_d.st     = ST_REF_CAS;
                    end
                end else if (accept) begin
                    s_d.wdata = host_wdata;
                    s_d.is_we = host_we;
                    s_d.be    = host_be;
                    s_d.col   = req_col;
                    if (req_hit) begin
                        s_d.pin   = PIN_W'(req_col);
                        s_d.we_n  = !host_we;
                        s_d.dq_oe = host_we;
                        s_d.st    = ST_COL_SET;
                    end else if (s_q.row_open) begin
                        s_d.ras_n    = 1'b1;
                        s_d.row_open = 1'b0;
                        s_d.row      = req_row;
                        s_d.cnt      = CNT_W'(T_RP - 1);
                        s_d.st       = ST_PRE_MISS;
                    end else begin
                        s_d.row = req_row;
                        s_d.pin = PIN_W'(req_row);
                        s_d.st  = ST_ROW_SET;
                    end
                end
            end
            ST_PRE_MISS: begin
                if (s_q.cnt == '0) begin
                    s_d.pin = PIN_W'(s_q.row);
                    s_d.st  = ST_ROW_SET;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_ROW_SET: begin
                s_d.ras_n    = 1'b0;
                s_d.row_open = 1'b1;
                s_d.cnt      = CNT_W'(T_RCD - 1);
                s_d.st       = ST_ROW_WAIT;
            end
            ST_ROW_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.pin   = PIN_W'(s_q.col);
                    s_d.we_n  = !s_q.is_we;
                    s_d.dq_oe = s_q.is_we;
                    s_d.st    = ST_COL_SET;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_COL_SET: begin
                s_d.lcas_n = !s_q.be[0];
                s_d.ucas_n = !s_q.be[1];
                s_d.oe_n   = s_q.is_we;
                s_d.cnt    = CNT_W'(T_CAS - 1);
                s_d.st     = ST_COL_LOW;
            end
            ST_COL_LOW: begin
                if (s_q.cnt == '0) begin
                    s_d.lcas_n = 1'b1;
                    s_d.ucas_n = 1'b1;
                    s_d.oe_n   = 1'b1;
                    s_d.we_n   = 1'b1;
                    s_d.dq_oe  = 1'b0;
                    if (!s_q.is_we) begin
                        s_d.rsp_valid = 1'b1;
                        s_d.rdata     = {s_q.be[1] ? mem_dq_in[DATA_W-1:LANE_W] : {LANE_W{1'b0}},
                                         s_q.be[0] ? mem_dq_in[LANE_W-1:0]      : {LANE_W{1'b0}}};
                    end
                    s_d.cnt = CNT_W'(T_CP - 1);
                    s_d.st  = ST_COL_REC;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_COL_REC: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_PRE_REF: begin
                if (s_q.cnt == '0) begin
                    s_d.lcas_n = 1'b0;
                    s_d.ucas_n = 1'b0;
                    s_d.cnt    = CNT_W'(T_CSR - 1);
                    s_d.st     = ST_REF_CAS;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_REF_CAS: begin
                if (s_q.cnt == '0) begin
                    s_d.ras_n = 1'b0;
                    s_d.cnt   = CNT_W'(T_RAS_REF - 1);
                    s_d.st    = ST_REF_RAS;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_REF_RAS: begin
                if (s_q.cnt == '0) begin
                    s_d.ras_n  = 1'b1;
                    s_d.lcas_n = 1'b1;
                    s_d.ucas_n = 1'b1;
                    s_d.cnt    = CNT_W'(T_RP - 1);
                    s_d.st     = ST_REF_REC;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_REF_REC: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: s_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RESET_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_rdata  = s_q.rdata;
    assign mem_ras_n  = s_q.ras_n;
    assign mem_lcas_n = s_q.lcas_n;
    assign mem_ucas_n = s_q.ucas_n;
    assign mem_we_n   = s_q.we_n;
    assign mem_oe_n   = s_q.oe_n;
    assign mem_addr   = s_q.pin;
    assign mem_dq_out = s_q.wdata;
    assign mem_dq_oe  = s_q.dq_oe;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
    parameter int PIN_W = 10,
    parameter int T_RP  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_ready,
    input logic             rsp_valid,
    input logic             mem_ras_n,
    input logic             mem_lcas_n,
    input logic             mem_ucas_n,
    input logic             mem_we_n,
    input logic             mem_oe_n,
    input logic [PIN_W-1:0] mem_addr
);
    localparam int HW = $clog2(T_RP + 2) + 1;
    localparam logic [HW-1:0] HMAX = {HW{1'b1}};

    logic [HW-1:0] high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run <= HMAX;
        end else if (!mem_ras_n) begin
            high_run <= '0;
        end else if (high_run != HMAX) begin
            high_run <= high_run + HW'(1);
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_ras_n && mem_lcas_n && mem_ucas_n && mem_we_n && mem_oe_n && !rsp_valid));

    p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(mem_lcas_n) || $fell(mem_ucas_n)) && !mem_we_n) |-> ($past(!mem_we_n) && mem_oe_n));

    p_read_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !(mem_lcas_n && mem_ucas_n)));

    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (high_run >= HW'(T_RP)));

    p_cbr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ras_n && !mem_lcas_n) |-> (mem_we_n && mem_oe_n));

    p_cbr_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ras_n && !mem_lcas_n && !mem_ucas_n) |=> $stable(mem_addr));

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_lcas_n && mem_ucas_n && mem_oe_n && mem_we_n));
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.PIN_W(PIN_W), .T_RP(T_RP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .rsp_valid  (rsp_valid),
    .mem_ras_n  (mem_ras_n),
    .mem_lcas_n (mem_lcas_n),
    .mem_ucas_n (mem_ucas_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_addr   (mem_addr)
);

// File: tb/test_edo_page_ctrl.sv
`timescale 1ns/1ps
module test_edo_page_ctrl;
    localparam int CLK_MHZ  = 3;
    localparam int T_RP     = 2;
    localparam int EXP_GAP  = 128000 * CLK_MHZ / 1024;
    localparam int NVEC     = 12;

    // {we, be[1:0], addr[19:0], wdata[15:0], expected rdata[15:0], new row strobe}
    localparam logic [55:0] VEC [NVEC] = '{
        {1'b1, 2'b11, 20'h00C01, 16'hA5A5, 16'h0000, 1'b1},
        {1'b1, 2'b11, 20'h00C02, 16'h1111, 16'h0000, 1'b0},
        {1'b0, 2'b11, 20'h00C01, 16'h0000, 16'hA5A5, 1'b0},
        {1'b1, 2'b01, 20'h00C01, 16'h3C77, 16'h0000, 1'b0},
        {1'b0, 2'b11, 20'h00C01, 16'h0000, 16'hA577, 1'b0},
        {1'b0, 2'b10, 20'h00C01, 16'h0000, 16'hA500, 1'b0},
        {1'b1, 2'b10, 20'h01401, 16'h9900, 16'h0000, 1'b1},
        {1'b0, 2'b11, 20'h01401, 16'h0000, 16'h9900, 1'b0},
        {1'b0, 2'b11, 20'h00C02, 16'h0000, 16'h1111, 1'b1},
        {1'b0, 2'b01, 20'h00C02, 16'h0000, 16'h0011, 1'b0},
        {1'b1, 2'b11, 20'hFDFF9, 16'hBEEF, 16'h0000, 1'b1},
        {1'b0, 2'b11, 20'hFDFF9, 16'h0000, 16'hBEEF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_we = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [9:0]  mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edo_page_ctrl #(
        .CLK_MHZ(CLK_MHZ), .EXT_REFRESH(1), .T_RCD(2), .T_CAS(2), .T_CP(1),
        .T_RP(T_RP), .T_CSR(1), .T_RAS_REF(3)
    ) i_edo_page_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ras_n(mem_ras_n),
        .mem_lcas_n(mem_lcas_n), .mem_ucas_n(mem_ucas_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural DRAM model, sampled away from the active edge
    logic [15:0] mem [256];
    logic [9:0]  lat_row = '0, lat_col = '0, cbr_addr = '0;
    logic        p_ras = 1'b1, p_lcas = 1'b1, p_ucas = 1'b1, p_we = 1'b1;
    int          high_cnt = 100;
    int          ras_falls = 0, ref_cnt = 0;
    longint      ref_time = 0;
    int          prech_bad = 0, early_bad = 0, cbr_bad = 0, ready_bad = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end

    assign mem_dq_in = !mem_oe_n ? mem[{lat_row[3:0], lat_col[3:0]}] : 16'h0000;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !mem_ras_n) begin
                if (high_cnt < T_RP) prech_bad++;
                if (!mem_lcas_n && !mem_ucas_n) begin
                    ref_cnt++;
                    ref_time = cyc;
                    if (mem_addr != cbr_addr || !mem_we_n || !mem_oe_n) cbr_bad++;
                end else begin
                    ras_falls++;
                    lat_row = mem_addr;
                end
            end
            if ((p_lcas && !mem_lcas_n) || (p_ucas && !mem_ucas_n)) begin
                if (mem_ras_n) begin
                    cbr_addr = mem_addr;
                    if (!(p_lcas && p_ucas && !mem_lcas_n && !mem_ucas_n)) cbr_bad++;
                end else begin
                    lat_col = mem_addr;
                    if (!mem_we_n) begin
                        if (p_we || !mem_oe_n || !mem_dq_oe) early_bad++;
                        if (!mem_lcas_n) mem[{lat_row[3:0], mem_addr[3:0]}][7:0]  = mem_dq_out[7:0];
                        if (!mem_ucas_n) mem[{lat_row[3:0], mem_addr[3:0]}][15:8] = mem_dq_out[15:8];
                    end
                end
            end
            if (host_ready && (!mem_lcas_n || !mem_ucas_n)) ready_bad++;
            if (mem_ras_n) high_cnt++; else high_cnt = 0;
        end
        p_ras  = mem_ras_n;
        p_lcas = mem_lcas_n;
        p_ucas = mem_ucas_n;
        p_we   = mem_we_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit we, input logic [1:0] be, input logic [19:0] addr,
                         input logic [15:0] wdata, output logic [15:0] rdata,
                         output int new_ras, output bit pulse_ok);
        int ras0;
        @(negedge clk);
        host_valid = 1'b1;
        host_we    = we;
        host_be    = be;
        host_addr  = addr;
        host_wdata = wdata;
        while (!host_ready) @(negedge clk);
        ras0 = ras_falls;
        @(negedge clk);
        host_valid = 1'b0;
        rdata    = '0;
        pulse_ok = 1'b1;
        if (!we) begin
            while (!rsp_valid) @(negedge clk);
            rdata = rsp_rdata;
            @(negedge clk);
            pulse_ok = !rsp_valid;
        end
        while (!host_ready) @(negedge clk);
        new_ras = ras_falls - ras0;
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        int nr;
        bit pok;
        int ref0, nr_sum;
        longint t1;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_ras_n && mem_lcas_n && mem_ucas_n && mem_we_n && mem_oe_n, "R1",
              "strobes during reset", {mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n, mem_oe_n}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && !rsp_valid && mem_ras_n && mem_lcas_n && mem_ucas_n, "R1",
              "ready/strobes after reset", {host_ready, rsp_valid}, 2'b10);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [55:0] e;
            e = VEC[v];
            do_op(e[55], e[54:53], e[52:33], e[32:17], rd, nr, pok);
            check(lat_row == e[52:43] && lat_col == e[42:33], "R2", $sformatf("row/col vec %0d", v),
                  {lat_row, lat_col}, e[52:33]);
            check(nr == int'(e[0]), e[0] ? "R7" : "R6", $sformatf("row strobe falls vec %0d", v),
                  nr, e[0]);
            if (!e[55]) begin
                check(rd == e[16:1], "R3", $sformatf("read data vec %0d", v), rd, e[16:1]);
                check(pok, "R5", $sformatf("single-cycle rsp vec %0d", v), pok, 1);
            end
        end
        check(early_bad == 0, "R4", "early write order", early_bad, 0);
        check(prech_bad == 0, "R7", "row precharge time", prech_bad, 0);

        // R9: refresh spacing while idle
        ref0 = ref_cnt;
        wait (ref_cnt == ref0 + 1);
        wait (ref_cnt == ref0 + 2);
        t1 = ref_time;
        wait (ref_cnt == ref0 + 3);
        check(ref_time - t1 == EXP_GAP, "R9", "refresh spacing", ref_time - t1, EXP_GAP);
        check(cbr_bad == 0, "R8", "CAS-before-RAS order, quiet address", cbr_bad, 0);

        // R10: refresh closed the row, so the same row reopens
        do_op(1'b0, 2'b11, 20'hFDFF9, 16'h0, rd, nr, pok);
        check(nr == 1, "R10", "reopen after refresh", nr, 1);
        check(rd == 16'hBEEF, "R10", "data after refresh", rd, 16'hBEEF);

        // R10/R11: back-to-back stream across refreshes
        do_op(1'b0, 2'b11, 20'h00C01, 16'h0, rd, nr, pok);
        ref0   = ref_cnt;
        nr_sum = 0;
        for (int k = 0; k < 100; k++) begin
            logic [15:0] exp_d;
            exp_d = k[0] ? 16'h1111 : 16'hA577;
            do_op(1'b0, 2'b11, k[0] ? 20'h00C02 : 20'h00C01, 16'h0, rd, nr, pok);
            nr_sum += nr;
            if (rd != exp_d) check(1'b0, "R10", $sformatf("stream read %0d", k), rd, exp_d);
        end
        check(ref_cnt - ref0 >= 1, "R10", "refresh served in stream", ref_cnt - ref0, 1);
        check(nr_sum == ref_cnt - ref0, "R10", "row reopen per refresh", nr_sum, ref_cnt - ref0);
        check(ready_bad == 0, "R11", "ready low during column/refresh", ready_bad, 0);
        check(cbr_bad == 0 && prech_bad == 0, "R8", "refresh timing in stream", cbr_bad + prech_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule